// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one channel of a four-channel DMA controller through single transfer cycles. Software loads a base address, a base count and a page value. It then unmasks the channel. From then on, a hardware request line or a software request bit starts transfers. Each transfer takes one cycle with DACK high. In that cycle the block drives a physical memory address and, depending on the transfer type, a write or read strobe. In the following cycle the current address and count are updated and DACK drops. A new transfer can begin the cycle after that.

The current count counts down. When it wraps past zero, the channel has reached terminal count. The channel then either reloads its base values (auto-initialize) or stops. When it stops, it sets its terminal-count status, masks itself and pulses a request-clear output for the software request bit. A command input can hold the address fixed, another can disable the controller, and a cascade mode input stops the channel from transferring. The data path is outside the block and is represented only by the strobes.

Top module: `dma_chan_seq`

## Requirements
- R1: After synchronous reset the current and base registers are zero, `tc_status` is 0, DACK and both strobes are low, and the channel is masked: a request gets no DACK until a write with `mask_wr`=1 and `mask_val`=0.
- R2: A transfer starts on the clock edge where a request (`drq` or `sw_req`) is seen in the idle state. DACK and `mem_addr` are then valid for exactly one cycle, and DACK is low for at least one cycle between transfers. Transfers repeat while a request stays active.
- R3: Transfer type `mode[1:0]`: 0 = verify, with neither strobe; 1 = `mem_wr` high during the DACK cycle; 2 = `mem_rd` high during the DACK cycle; 3 = no strobe. DACK is raised for all four types.
- R4: After each transfer the 16-bit current address moves by one: up when `mode[3]`=0, down when `mode[3]`=1. It wraps modulo 2^16, and the page value is not affected.
- R5: While `cmd_hold`=1 the current address does not change after a transfer.
- R6: The current count decrements after each transfer. A loaded count N gives N+1 transfers before terminal count. `tc_pulse` is high for one cycle, the cycle after the DACK of the transfer that finds the count at zero.
- R7: On terminal count with `mode[2]`=0, in the same cycle as `tc_pulse`, `tc_status` goes to 1 and `mask_set` and `req_clr` each pulse for one cycle. No further DACK follows while a request stays active.
- R8: On terminal count with `mode[2]`=1, the current address and count reload from the base values, `tc_status` stays unchanged, and transfers continue.
- R9: No transfer starts while `cmd_disable`=1 or `mode_cascade`=1.
- R10: `mem_addr` = (page << 16) | (current address << WORD_XFER). WORD_XFER=1 selects a word channel.
- R11: `status_clr`=1, or an unmask write, clears `tc_status`. If either falls in the same cycle as a stopping terminal count, the terminal count wins: `tc_status` stays 1 and the channel stays masked.
- R12: A write with `mask_wr`=1 and `mask_val`=1 masks the channel. A request that arrives while masked, or while a transfer is in its DACK cycle, gets no new DACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load base and current address, count and page |
| cfg_addr | input | 16 | Start address to load |
| cfg_count | input | 16 | Transfer count minus one to load |
| cfg_page | input | 8 | Page value to load |
| mode | input | 4 | [1:0] transfer type, [2] auto-initialize, [3] count address down |
| mode_cascade | input | 1 | Channel is in cascade mode (no transfers) |
| cmd_hold | input | 1 | Hold the address constant |
| cmd_disable | input | 1 | Controller disabled |
| mask_wr | input | 1 | Write the mask bit |
| mask_val | input | 1 | Mask value written when mask_wr is high |
| status_clr | input | 1 | Clear the terminal-count status |
| drq | input | 1 | Hardware request |
| sw_req | input | 1 | Software request bit |
| dack | output | 1 | Transfer acknowledge; high in the transfer cycle |
| mem_addr | output | 24 | Physical memory address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| tc_status | output | 1 | Terminal-count status bit |
| mask_set | output | 1 | One-cycle pulse when terminal count masks the channel |
| req_clr | output | 1 | One-cycle pulse that clears the software request bit |

## Verification
A stopping terminal count and a software unmask write can land on the same clock edge. The bench forces this by loading a count of zero and raising the request. It then asserts the unmask write during the DACK cycle, so the write is sampled on the edge where the count wraps. The result is correct if `tc_status` reads 1 afterwards and a request that stays high produces no further DACK. A later separate unmask must then clear the status.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    XT_VERIFY  = 2'd0,
    XT_WRITE   = 2'd1,
    XT_READ    = 2'd2,
    XT_INVALID = 2'd3
  } xfer_type_t;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_XFER = 1'b1
  } ch_state_t;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW     = 16,
  parameter int PW     = 8,
  parameter int WORD   = 0,
  parameter int PHYS_W = PW + AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     load_addr,
  input  logic [PW-1:0]     load_page,
  input  logic              latch,
  input  logic              step,
  input  logic              reload,
  input  logic              hold,
  input  logic              down,
  output logic [PHYS_W-1:0] phys_q
);
  logic [AW-1:0]     base_q;
  logic [AW-1:0]     cur_q;
  logic [PW-1:0]     page_q;
  logic [PHYS_W-1:0] phys_next;

  assign phys_next = (PHYS_W'(page_q) << AW) | (PHYS_W'(cur_q) << WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
      page_q <= '0;
      phys_q <= '0;
    end else begin
      if (load) begin
        base_q <= load_addr;
        cur_q  <= load_addr;
        page_q <= load_page;
      end else if (step) begin
        if (reload)     cur_q <= base_q;
        else if (!hold) cur_q <= down ? cur_q - AW'(1) : cur_q + AW'(1);
      end
      if (latch) phys_q <= phys_next;
    end
  end

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (step && hold && !reload && !load) |=> (cur_q == $past(cur_q)));

  assert_addr_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (step && reload && !load) |=> (cur_q == $past(base_q)));
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_count,
  input  logic          step,
  input  logic          reload,
  output logic          terminal
);
  logic [CW-1:0] base_q;
  logic [CW-1:0] cur_q;

  assign terminal = (cur_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= load_count;
      cur_q  <= load_count;
    end else if (step) begin
      cur_q <= reload ? base_q : cur_q - CW'(1);
    end
  end

  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !reload && !load) |=> (cur_q == $past(cur_q) - CW'(1)));
endmodule

// File: rtl/dma_cycle_ctrl.sv
module dma_cycle_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       drq,
  input  logic       sw_req,
  input  logic       cmd_disable,
  input  logic       mode_cascade,
  input  logic [1:0] xfer_type,
  input  logic       autoinit,
  input  logic       mask_wr,
  input  logic       mask_val,
  input  logic       status_clr,
  input  logic       terminal,
  output logic       go,
  output logic       step,
  output logic       dack,
  output logic       mem_wr,
  output logic       mem_rd,
  output logic       tc_pulse,
  output logic       tc_status,
  output logic       mask_set,
  output logic       req_clr
);
  ch_state_t state_q;
  logic      mask_q;
  logic      tc_stop;

  assign go      = (state_q == CH_IDLE) && (drq || sw_req) && !mask_q &&
                   !tc_status && !cmd_disable && !mode_cascade;
  assign step    = (state_q == CH_XFER);
  assign tc_stop = step && terminal && !autoinit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CH_IDLE;
      dack      <= 1'b0;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      tc_pulse  <= 1'b0;
      tc_status <= 1'b0;
      mask_q    <= 1'b1;
      mask_set  <= 1'b0;
      req_clr   <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      mask_set <= 1'b0;
      req_clr  <= 1'b0;
      if (go) begin
        state_q <= CH_XFER;
        dack    <= 1'b1;
        mem_wr  <= (xfer_type == XT_WRITE);
        mem_rd  <= (xfer_type == XT_READ);
      end else if (step) begin
        state_q  <= CH_IDLE;
        dack     <= 1'b0;
        mem_wr   <= 1'b0;
        mem_rd   <= 1'b0;
        tc_pulse <= terminal;
      end
      if (tc_stop) begin
        tc_status <= 1'b1;
        mask_q    <= 1'b1;
        mask_set  <= 1'b1;
        req_clr   <= 1'b1;
      end else begin
        if (mask_wr) mask_q <= mask_val;
        if ((mask_wr && !mask_val) || status_clr) tc_status <= 1'b0;
      end
    end
  end

  assert_dack_single_R2: assert property (@(posedge clk) disable iff (rst)
    dack |=> !dack);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd));

  assert_strobe_in_dack_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || mem_rd) |-> dack);

  assert_tc_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (step && terminal && !autoinit) |=> (tc_status && mask_set && req_clr && tc_pulse));

  assert_auto_keeps_status_R8: assert property (@(posedge clk) disable iff (rst)
    (step && terminal && autoinit && !mask_wr && !status_clr) |=> $stable(tc_status));

  assert_masked_no_dack_R12: assert property (@(posedge clk) disable iff (rst)
    (mask_q && !dack) |=> !dack);

  assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!dack && (cmd_disable || mode_cascade)) |=> !dack);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PW        = 8,
  parameter int WORD_XFER = 0,
  localparam int PHYS_W   = PW + AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [AW-1:0]     cfg_count,
  input  logic [PW-1:0]     cfg_page,
  input  logic [3:0]        mode,
  input  logic              mode_cascade,
  input  logic              cmd_hold,
  input  logic              cmd_disable,
  input  logic              mask_wr,
  input  logic              mask_val,
  input  logic              status_clr,
  input  logic              drq,
  input  logic              sw_req,
  output logic              dack,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              tc_pulse,
  output logic              tc_status,
  output logic              mask_set,
  output logic              req_clr
);
  logic go;
  logic step;
  logic terminal;
  logic reload;

  assign reload = step && terminal && mode[2];

  dma_cycle_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .drq          (drq),
    .sw_req       (sw_req),
    .cmd_disable  (cmd_disable),
    .mode_cascade (mode_cascade),
    .xfer_type    (mode[1:0]),
    .autoinit     (mode[2]),
    .mask_wr      (mask_wr),
    .mask_val     (mask_val),
    .status_clr   (status_clr),
    .terminal     (terminal),
    .go           (go),
    .step         (step),
    .dack         (dack),
    .mem_wr       (mem_wr),
    .mem_rd       (mem_rd),
    .tc_pulse     (tc_pulse),
    .tc_status    (tc_status),
    .mask_set     (mask_set),
    .req_clr      (req_clr)
  );

  dma_addr_unit #(.AW(AW), .PW(PW), .WORD(WORD_XFER)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_load),
    .load_addr (cfg_addr),
    .load_page (cfg_page),
    .latch     (go),
    .step      (step),
    .reload    (reload),
    .hold      (cmd_hold),
    .down      (mode[3]),
    .phys_q    (mem_addr)
  );

  dma_count_unit #(.CW(AW)) u_count (
    .clk        (clk),
    .rst        (rst),
    .load       (cfg_load),
    .load_count (cfg_count),
    .step       (step),
    .reload     (reload),
    .terminal   (terminal)
  );
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 0, mode_cascade = 0, cmd_hold = 0, cmd_disable = 0;
  logic mask_wr = 0, mask_val = 0, status_clr = 0, drq = 0, sw_req = 0;
  logic [15:0] cfg_addr = 0, cfg_count = 0;
  logic [7:0]  cfg_page = 0;
  logic [3:0]  mode = 0;
  logic dack, mem_wr, mem_rd, tc_pulse, tc_status, mask_set, req_clr;
  logic [23:0] mem_addr;
  logic w_dack, w_wr, w_rd, w_tc, w_tcs, w_ms, w_rc;
  logic [23:0] w_addr;

  typedef struct packed {
    logic [23:0] a;
    logic [23:0] aw;
    logic wr;
    logic rd;
    logic tc;
  } item_t;
  item_t exp_q[$];

  int checks = 0, errors = 0;
  int dack_seen = 0, mset_seen = 0, rclr_seen = 0;
  logic tc_pend = 0, tc_exp = 0;

  always #4 clk = ~clk;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
    .cfg_page(cfg_page), .mode(mode), .mode_cascade(mode_cascade), .cmd_hold(cmd_hold),
    .cmd_disable(cmd_disable), .mask_wr(mask_wr), .mask_val(mask_val), .status_clr(status_clr),
    .drq(drq), .sw_req(sw_req), .dack(dack), .mem_addr(mem_addr), .mem_wr(mem_wr),
    .mem_rd(mem_rd), .tc_pulse(tc_pulse), .tc_status(tc_status), .mask_set(mask_set),
    .req_clr(req_clr));

  dma_chan_seq #(.WORD_XFER(1)) i_dma_chan_seq_w (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_addr(cfg_addr), .cfg_count(cfg_count),
    .cfg_page(cfg_page), .mode(mode), .mode_cascade(mode_cascade), .cmd_hold(cmd_hold),
    .cmd_disable(cmd_disable), .mask_wr(mask_wr), .mask_val(mask_val), .status_clr(status_clr),
    .drq(drq), .sw_req(sw_req), .dack(w_dack), .mem_addr(w_addr), .mem_wr(w_wr),
    .mem_rd(w_rd), .tc_pulse(w_tc), .tc_status(w_tcs), .mask_set(w_ms), .req_clr(w_rc));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (!rst) begin
      if (tc_pend) begin
        check("R6 tc_pulse", tc_pulse, tc_exp);
        tc_pend = 0;
      end else if (tc_pulse) begin
        check("R6 unexpected tc_pulse", 1, 0);
      end
      if (mask_set) mset_seen++;
      if (req_clr)  rclr_seen++;
      if (dack) begin
        item_t it;
        dack_seen++;
        if (exp_q.size() == 0) begin
          check("R12 unexpected dack", 1, 0);
        end else begin
          it = exp_q.pop_front();
          check("R10 R4 mem_addr", mem_addr, it.a);
          check("R10 word mem_addr", w_addr, it.aw);
          check("R3 mem_wr", mem_wr, it.wr);
          check("R3 mem_rd", mem_rd, it.rd);
          tc_pend = 1;
          tc_exp  = it.tc;
        end
      end
    end
  end

  task automatic load_unmask(input [7:0] pg, input [15:0] ad, input [15:0] cn,
                             input [3:0] md, input logic hold);
    @(negedge clk);
    mode = md; cmd_hold = hold;
    cfg_page = pg; cfg_addr = ad; cfg_count = cn; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0; mask_wr = 1; mask_val = 0;
    @(negedge clk);
    mask_wr = 0;
  endtask

  task automatic push_model(input [7:0] pg, input [15:0] ad, input [15:0] cn,
                            input [3:0] md, input logic hold, input int n);
    logic [15:0] a = ad;
    logic [15:0] c = cn;
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.a  = {pg, a};
      it.aw = {pg, 16'h0} | (24'(a) << 1);
      it.wr = (md[1:0] == 2'd1);
      it.rd = (md[1:0] == 2'd2);
      it.tc = (c == 16'h0);
      exp_q.push_back(it);
      if (c == 16'h0 && md[2]) begin
        a = ad; c = cn;
      end else begin
        c = c - 16'h1;
        if (!hold) a = md[3] ? a - 16'h1 : a + 16'h1;
      end
    end
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0);
  endtask

  initial begin
    int d0, m0, r0;
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 dack after reset", dack, 0);
    check("R1 mem_addr after reset", mem_addr, 0);
    check("R1 tc_status after reset", tc_status, 0);
    check("R1 strobes after reset", {mem_wr, mem_rd}, 0);
    drq = 1;
    repeat (6) @(negedge clk);
    check("R1 masked after reset, no dack", dack_seen, 0);
    drq = 0;

    // R2 R3 R4 R6 R7: write, increment, count 2 -> 3 transfers, stop at TC
    load_unmask(8'h12, 16'h1000, 16'd2, 4'b0001, 0);
    m0 = mset_seen; r0 = rclr_seen;
    push_model(8'h12, 16'h1000, 16'd2, 4'b0001, 0, 3);
    drq = 1;
    drain();
    d0 = dack_seen;
    repeat (8) @(negedge clk);
    check("R7 no dack after terminal count", dack_seen - d0, 0);
    check("R7 tc_status set", tc_status, 1);
    check("R7 mask_set pulse", mset_seen - m0, 1);
    check("R7 req_clr pulse", rclr_seen - r0, 1);
    drq = 0;
    // R11 status clear
    @(negedge clk); status_clr = 1;
    @(negedge clk); status_clr = 0;
    check("R11 status_clr clears tc_status", tc_status, 0);

    // R4 R3 read, decrement
    load_unmask(8'h03, 16'h0005, 16'd1, 4'b1010, 0);
    push_model(8'h03, 16'h0005, 16'd1, 4'b1010, 0, 2);
    drq = 1; drain(); repeat (4) @(negedge clk); drq = 0;

    // R4 wrap at 16 bits, page unchanged
    load_unmask(8'h40, 16'hFFFF, 16'd1, 4'b0001, 0);
    push_model(8'h40, 16'hFFFF, 16'd1, 4'b0001, 0, 2);
    drq = 1; drain(); repeat (4) @(negedge clk); drq = 0;

    // R5 hold, verify type (no strobes), via software request (R2)
    load_unmask(8'h07, 16'h0200, 16'd2, 4'b0000, 1);
    push_model(8'h07, 16'h0200, 16'd2, 4'b0000, 1, 3);
    sw_req = 1; drain(); repeat (4) @(negedge clk); sw_req = 0;

    // R3 invalid type: dack, no strobe
    load_unmask(8'h01, 16'h0030, 16'd0, 4'b0011, 0);
    push_model(8'h01, 16'h0030, 16'd0, 4'b0011, 0, 1);
    drq = 1; drain(); repeat (4) @(negedge clk); drq = 0;

    // R8 auto-initialize: count 1, five transfers, tc_status untouched
    load_unmask(8'h22, 16'h0010, 16'd1, 4'b0101, 0);
    m0 = mset_seen;
    push_model(8'h22, 16'h0010, 16'd1, 4'b0101, 0, 5);
    drq = 1; drain(); drq = 0;
    repeat (4) @(negedge clk);
    check("R8 tc_status stays clear under auto-init", tc_status, 0);
    check("R8 no mask_set under auto-init", mset_seen - m0, 0);

    // R9 disable and cascade
    load_unmask(8'h00, 16'h0100, 16'd3, 4'b0001, 0);
    d0 = dack_seen;
    cmd_disable = 1; drq = 1;
    repeat (6) @(negedge clk);
    check("R9 no dack while disabled", dack_seen - d0, 0);
    drq = 0; cmd_disable = 0; mode_cascade = 1; drq = 1;
    repeat (6) @(negedge clk);
    check("R9 no dack in cascade mode", dack_seen - d0, 0);
    drq = 0; mode_cascade = 0;

    // R12 mask write stops a running channel
    load_unmask(8'h00, 16'h0100, 16'd5, 4'b0001, 0);
    push_model(8'h00, 16'h0100, 16'd5, 4'b0001, 0, 2);
    drq = 1; drain();
    mask_wr = 1; mask_val = 1;
    @(negedge clk); mask_wr = 0;
    d0 = dack_seen;
    repeat (6) @(negedge clk);
    check("R12 no dack after mask write", dack_seen - d0, 0);
    drq = 0;

    // R11 terminal count and unmask write on the same edge: TC wins
    load_unmask(8'h05, 16'h0050, 16'd0, 4'b0001, 0);
    push_model(8'h05, 16'h0050, 16'd0, 4'b0001, 0, 1);
    drq = 1;
    drain();               // negedge inside the DACK cycle
    mask_wr = 1; mask_val = 0;
    @(negedge clk); mask_wr = 0;
    d0 = dack_seen;
    check("R11 TC wins over unmask: tc_status", tc_status, 1);
    repeat (6) @(negedge clk);
    check("R11 TC wins over unmask: still masked", dack_seen - d0, 0);
    drq = 0;
    @(negedge clk); mask_wr = 1; mask_val = 0;
    @(negedge clk); mask_wr = 0;
    check("R11 later unmask clears tc_status", tc_status, 0);

    repeat (4) @(negedge clk);
    check("R2 all expected transfers seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule